// File: doc/BRIEF.md
# Accumulator Field Select and Gain Stage

This stage sits at the output of a convolution datapath. It receives a 32-bit two's complement accumulator result every clock and turns it into a 16-bit output word and an overflow flag. A 2-bit select input picks one of two overlapping 20-bit windows of the accumulator. One is the low window, bits [19:0]. The other is the window four bits higher, bits [23:4]. Accumulator bits outside the chosen window are not used.

The chosen window is treated as a signed 20-bit value and shifted left by a programmable gain of 0 to 4 bits. The gain is picked so that the significant part of the result fills the output. The output word is the top 16 bits of the shifted 20-bit value. If the shift pushes significant bits out of the 20-bit range, the overflow flag is raised and the word saturates to the extreme of the window's sign. Both outputs are registered, so results appear one cycle after their input.

Top module: `acc_scale`

## Requirements
- R1: While rst is high at a clock edge, out_word becomes 16'h0000 and ovf becomes 0.
- R2: With sel = 2'b00 the working field is acc[19:0], taken as signed.
- R3: With sel = 2'b01 the working field is acc[23:4], taken as signed.
- R4: The select codes 2'b10 and 2'b11 give the same result as 2'b00.
- R5: For a gain code g from 0 to 4, the field is multiplied by 2^g and out_word is bits [19:4] of that 20-bit product.
- R6: The gain codes 5, 6 and 7 behave exactly like gain 4.
- R7: When the product lies outside the range -524288 to 524287, ovf is 1 and out_word is 16'h7FFF for a non-negative field or 16'h8000 for a negative field. Otherwise ovf is 0.
- R8: out_word and ovf both reflect the inputs present at the previous rising clock edge: a latency of exactly one cycle, with the flag aligned to its word.
- R9: Accumulator bits outside the selected field (acc[31:20] for the low field, acc[31:24] and acc[3:0] for the high field) have no effect on either output.
- R10: With gain 0, ovf is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| acc | input | 32 | Accumulator result, two's complement |
| sel | input | 2 | Field select: 01 high window, any other code low window |
| gain | input | 3 | Left-shift amount; codes above 4 clamp to 4 |
| out_word | output | 16 | Scaled and saturated result, registered |
| ovf | output | 1 | Overflow flag for the word on out_word |

## Verification
The assertions assume that acc, sel and gain are stable and defined at every rising edge once reset is released. They also assume the inputs may change on every cycle, because the stage has no hold or enable. The stimulus changes inputs only on falling edges. It drives one full set of values per cycle and never leaves an input undriven. It fills the bits outside the selected field with patterns that would change the result if they were used. It also covers both sign polarities near the exact 20-bit boundaries.

// File: rtl/acc_scale_pkg.sv
package acc_scale_pkg;

    localparam int ACC_W   = 32;
    localparam int FIELD_W = 20;
    localparam int OUT_W   = 16;
    localparam int HI_OFS  = 4;
    localparam int GAIN_W  = 3;
    localparam int GAIN_MAX = 4;
    localparam int EXT_W   = FIELD_W + GAIN_MAX;
    localparam int DROP_W  = FIELD_W - OUT_W;

    typedef enum logic [1:0] {
        WIN_LOW   = 2'b00,
        WIN_HIGH  = 2'b01,
        WIN_RSV_A = 2'b10,
        WIN_RSV_B = 2'b11
    } win_sel_e;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             ovf;
    } scaled_t;

    function automatic logic [GAIN_W-1:0] clamp_gain(input logic [GAIN_W-1:0] g);
        return (g > GAIN_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX) : g;
    endfunction

    function automatic logic [OUT_W-1:0] sat_word(input logic neg);
        return neg ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/acc_field_pick.sv
module acc_field_pick
    import acc_scale_pkg::*;
(
    input  logic [ACC_W-1:0]   acc,
    input  logic [1:0]         sel,
    output logic [FIELD_W-1:0] field
);
    win_sel_e mode;

    always_comb begin
        mode = win_sel_e'(sel);
        unique case (mode)
            WIN_HIGH: field = acc[HI_OFS +: FIELD_W];
            default:  field = acc[0 +: FIELD_W];
        endcase
    end
endmodule

// File: rtl/acc_gain_sat.sv
module acc_gain_sat
    import acc_scale_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic [GAIN_W-1:0]  gain,
    output scaled_t            res
);
    logic [GAIN_W-1:0] g_eff;
    logic [EXT_W-1:0]  ext;
    logic [EXT_W-1:0]  shifted;
    logic [GAIN_MAX:0] top_bits;
    logic              lost;

    always_comb begin
        g_eff    = clamp_gain(gain);
        ext      = {{GAIN_MAX{field[FIELD_W-1]}}, field};
        shifted  = ext << g_eff;
        top_bits = shifted[EXT_W-1 -: (GAIN_MAX+1)];
        lost     = !((&top_bits) || (~|top_bits));
        res.ovf  = lost;
        res.word = lost ? sat_word(field[FIELD_W-1])
                        : shifted[DROP_W +: OUT_W];
    end
endmodule

// File: rtl/acc_scale.sv
module acc_scale
    import acc_scale_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] acc,
    input  logic [1:0]  sel,
    input  logic [2:0]  gain,
    output logic [15:0] out_word,
    output logic        ovf
);
    logic [FIELD_W-1:0] field;
    scaled_t            comb_res;
    scaled_t            res_q;

    acc_field_pick u_pick (
        .acc   (acc),
        .sel   (sel),
        .field (field)
    );

    acc_gain_sat u_gain (
        .field (field),
        .gain  (gain),
        .res   (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= comb_res;
    end

    assign out_word = res_q.word;
    assign ovf      = res_q.ovf;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_word == 16'h0000 && !ovf));

    // R7
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (out_word == 16'h7FFF || out_word == 16'h8000));

    // R7
    sat_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !$past(rst)) && ovf |->
            out_word[15] == ($past(sel) == 2'b01 ? $past(acc[23]) : $past(acc[19])));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (gain == 3'd0) |=> !ovf);

    // R4, R8
    low_unity_chk: assert property (@(posedge clk) disable iff (rst)
        (sel != 2'b01 && gain == 3'd0) |=> (out_word == $past(acc[19:4])));

    // R3, R8
    high_unity_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b01 && gain == 3'd0) |=> (out_word == $past(acc[23:8])));
endmodule

// File: tb/acc_scale_bench.sv
module acc_scale_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] acc = '0;
    logic [1:0]  sel = '0;
    logic [2:0]  gain = '0;
    logic [15:0] out_word;
    logic        ovf;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] word;
        logic        ovf;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    acc_scale u_acc_scale (
        .clk(clk), .rst(rst), .acc(acc), .sel(sel), .gain(gain),
        .out_word(out_word), .ovf(ovf)
    );

    function automatic exp_t model(logic [31:0] a, logic [1:0] s, logic [2:0] g, string r);
        exp_t e;
        logic signed [19:0] f;
        int fi, p, ge;
        f  = (s == 2'b01) ? a[23:4] : a[19:0];
        fi = f;
        ge = (g > 3'd4) ? 4 : int'(g);
        p  = fi * (1 << ge);
        e.req = r;
        if (p > 524287 || p < -524288) begin
            e.ovf  = 1'b1;
            e.word = (fi < 0) ? 16'h8000 : 16'h7FFF;
        end else begin
            e.ovf  = 1'b0;
            e.word = 16'(p >>> 4);
        end
        return e;
    endfunction

    task automatic drive(logic [31:0] a, logic [1:0] s, logic [2:0] g, string r);
        @(negedge clk);
        acc = a; sel = s; gain = g;
        sb.push_back(model(a, s, g, r));
    endtask

    // monitor: one result per cycle, one edge after its input
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (out_word !== e.word || ovf !== e.ovf) begin
                    errors++;
                    $display("FAIL %s: got word=%h ovf=%b expected word=%h ovf=%b",
                             e.req, out_word, ovf, e.word, e.ovf);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        acc = 32'hFFFF_FFFF; sel = 2'b01; gain = 3'd2;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_word !== 16'h0000 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1: got word=%h ovf=%b expected word=0000 ovf=0", out_word, ovf);
        end
        @(negedge clk);
        rst = 1'b0;

        drive(32'h0001_2345, 2'b00, 3'd0, "R2");
        drive(32'h0012_3450, 2'b01, 3'd0, "R3");
        drive(32'hABC1_2345, 2'b10, 3'd0, "R4");
        drive(32'h5A81_2345, 2'b11, 3'd1, "R4");
        drive(32'h0000_0ABC, 2'b00, 3'd1, "R5");
        drive(32'h0000_0ABC, 2'b00, 3'd2, "R5");
        drive(32'h0000_0ABC, 2'b00, 3'd3, "R5");
        drive(32'h0000_0ABC, 2'b00, 3'd4, "R5");
        drive(32'h000F_F000, 2'b00, 3'd2, "R5");
        drive(32'h0000_0ABC, 2'b00, 3'd5, "R6");
        drive(32'h0001_2345, 2'b01, 3'd6, "R6");
        drive(32'h000F_ABCD, 2'b00, 3'd7, "R6");
        drive(32'h0000_FFFF, 2'b00, 3'd3, "R7");
        drive(32'h0000_FFFF, 2'b00, 3'd4, "R7");
        drive(32'h000F_8000, 2'b00, 3'd4, "R7");
        drive(32'h000F_7FFF, 2'b00, 3'd4, "R7");
        drive(32'h0007_FFFF, 2'b00, 3'd1, "R7");
        drive(32'h0080_0000, 2'b01, 3'd1, "R7");
        drive(32'h0007_FFFF, 2'b00, 3'd0, "R10");
        drive(32'h0008_0000, 2'b00, 3'd0, "R10");
        drive(32'h0000_0010, 2'b00, 3'd0, "R8");
        drive(32'h0000_0020, 2'b00, 3'd0, "R8");
        drive(32'h0000_0030, 2'b00, 3'd0, "R8");
        drive(32'hFFF0_1230, 2'b00, 3'd2, "R9");
        drive(32'h0000_1230, 2'b00, 3'd2, "R9");
        drive(32'hFF01_234F, 2'b01, 3'd1, "R9");
        drive(32'h0001_2340, 2'b01, 3'd1, "R9");

        lf = 32'h1357_9BDF;
        for (int i = 0; i < 300; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            drive(lf, lf[9:8], lf[14:12], "R5");
        end

        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule